// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog Timer

This block is a free-running watchdog that raises a system reset request unless software services it correctly before a programmable timeout expires. A service is an ordered pair of byte writes to an arm register: first 0x55, then 0xAA. The pair restarts the timeout. A down counter sets the timeout. It advances on a reference tick input, and a 3-bit rate field selects a power-of-two period. A rate field of zero turns the watchdog off.

An optional window mode makes servicing stricter. Any arm write that arrives before three quarters of the period have elapsed counts as a fault. Control bits decide whether counting continues while the system is in wait or stop, and whether it halts while a debug session is active. After reset in special single-chip mode the watchdog starts at its longest period with window mode off.

Software writes a control register and the arm register through one write strobe with a select bit. The reset-sequencing logic that consumes the one-cycle reset request lies outside this block.

Top module: `keyseq_wdog`

## Requirements
- R1: A write with `wr_sel`=0 loads the control register from `wr_data[6:0]`. The fields are: bits [2:0] rate, bit 3 window enable, bit 4 run-in-wait, bit 5 run-in-stop, bit 6 halt-in-debug. The write restarts the full period of the new rate and returns the key sequence to expecting 0x55.
- R2: Rate values 1 to 7 select periods of 2^6, 2^8, 2^10, 2^12, 2^13, 2^14 and 2^16 counted ticks.
- R3: If P counted ticks pass with no completed service after a restart, `wdog_rst_req` goes high for exactly one cycle. It rises in the cycle after the edge that counts the P-th tick.
- R4: A write of 0x55 followed by a write of 0xAA to the arm register (`wr_sel`=1) restarts the full period without raising the reset request.
- R5: An arm write of a value other than the expected next key raises the reset request in the cycle after the write. This covers 0xAA with no preceding 0x55, 0x55 twice in a row, and any other byte.
- R6: Every reset request reloads the full period and returns the key sequence to expecting 0x55.
- R7: With window enable set, any arm write made before 3P/4 ticks have been counted since the restart raises the reset request. From the 3P/4-th tick on, keys are accepted.
- R8: With rate 0 the counter does not run, no reset request is raised, and arm writes are ignored.
- R9: On reset with `ssc_mode`=1 the rate is 7 and all other control bits are 0. With `ssc_mode`=0 the rate is the parameter `RST_RATE` (default 0) and the other bits are 0.
- R10: While `in_wait` is high and run-in-wait is 0, counting freezes. The same holds for `in_stop` with run-in-stop. When the run bit is 1, counting continues.
- R11: While `dbg_active` is high and halt-in-debug is 1, counting freezes. With halt-in-debug at 0 it continues.
- R12: The counter advances only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick; one count per high cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = arm register |
| wr_data | input | 8 | Write data |
| ssc_mode | input | 1 | Special single-chip mode, selects the reset defaults |
| in_wait | input | 1 | System is in wait |
| in_stop | input | 1 | System is in stop |
| dbg_active | input | 1 | Debug session active |
| wdog_rst_req | output | 1 | One-cycle reset request |

## Verification
The key logic is driven with a correct pair, a lone 0xAA, a repeated 0x55 and a stray byte. This separates the accepting path from each fault path, and a follow-up correct pair confirms that the sequence state was cleared. Window mode is probed with writes one tick before and one tick after the three-quarter point. This pins down the exact boundary, which an off-by-one comparison would move. The timeouts are measured as exact cycle counts for several rate codes and after each restart source (control write, service, fault), so a wrong table entry or a missed reload shows up as a count mismatch. Each freeze input is tried with its control bit both cleared and set, to show that the bit and not the input alone decides.

// File: rtl/keyseq_wdog_pkg.sv
package keyseq_wdog_pkg;

    localparam int RATE_W = 3;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 7;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

    // Control word, MSB first: halt-in-debug, run-in-stop, run-in-wait, window, rate
    typedef struct packed {
        logic              debug_halt;
        logic              stop_run;
        logic              wait_run;
        logic              win_en;
        logic [RATE_W-1:0] rate;
    } wd_ctrl_t;

    typedef enum logic {
        KS_WANT_FIRST  = 1'b0,
        KS_WANT_SECOND = 1'b1
    } key_state_t;

    function automatic int rate_log2(input logic [RATE_W-1:0] r);
        case (r)
            3'd1:    return 6;
            3'd2:    return 8;
            3'd3:    return 10;
            3'd4:    return 12;
            3'd5:    return 13;
            3'd6:    return 14;
            3'd7:    return 16;
            default: return 0;
        endcase
    endfunction

    // Counter load value: period minus one
    function automatic logic [CNT_W-1:0] rate_load(input logic [RATE_W-1:0] r);
        int k;
        k = rate_log2(r);
        if (k == 0) return '0;
        return CNT_W'((32'd1 << k) - 32'd1);
    endfunction

    // Counter values at or above this are in the early (closed) part of the period
    function automatic logic [CNT_W-1:0] rate_quarter(input logic [RATE_W-1:0] r);
        int k;
        k = rate_log2(r);
        if (k < 2) return '0;
        return CNT_W'(32'd1 << (k - 2));
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import keyseq_wdog_pkg::*;
#(
    parameter logic [RATE_W-1:0] RST_RATE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ssc_mode,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output wd_ctrl_t          ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            ctrl.rate <= ssc_mode ? {RATE_W{1'b1}} : RST_RATE;
        end else if (wr) begin
            ctrl <= wd_ctrl_t'(wdata);
        end
    end

endmodule

// File: rtl/wdog_modcnt.sv
module wdog_modcnt
    import keyseq_wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rst_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] quarter,
    input  logic             reload,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             early
);

    assign expire = cnt_en && (cnt == '0);
    assign early  = (cnt >= quarter);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= rst_load;
        end else if (reload) begin
            cnt <= load_val;
        end else if (cnt_en && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import keyseq_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              arm_wr,
    input  logic [DATA_W-1:0] data,
    input  logic              early_block,
    output key_state_t        state,
    output logic              key_ok,
    output logic              key_bad
);

    logic want_match;

    always_comb begin
        if (state == KS_WANT_FIRST) want_match = (data == KEY_FIRST);
        else                        want_match = (data == KEY_SECOND);
    end

    assign key_bad = arm_wr && (early_block || !want_match);
    assign key_ok  = arm_wr && !early_block && want_match && (state == KS_WANT_SECOND);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= KS_WANT_FIRST;
        end else if (arm_wr && !key_bad) begin
            state <= (state == KS_WANT_FIRST) ? KS_WANT_SECOND : KS_WANT_FIRST;
        end
    end

endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
    import keyseq_wdog_pkg::*;
#(
    parameter logic [RATE_W-1:0] RST_RATE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ssc_mode,
    input  logic              in_wait,
    input  logic              in_stop,
    input  logic              dbg_active,
    output logic              wdog_rst_req
);

    wd_ctrl_t          ctrl_q;
    key_state_t        key_st;
    logic [RATE_W-1:0] cur_rate;
    logic              win_on;
    logic              enabled;
    logic              ctrl_wr;
    logic              arm_wr;
    logic              cnt_en;
    logic              early;
    logic              expire;
    logic              key_ok;
    logic              key_bad;
    logic              fault;
    logic              reload;
    logic [CNT_W-1:0]  cur_load;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  rst_load;
    logic [CNT_W-1:0]  cnt_val;

    assign cur_rate = ctrl_q.rate;
    assign win_on   = ctrl_q.win_en;
    assign enabled  = (cur_rate != '0);
    assign ctrl_wr  = wr_en && !wr_sel;
    assign arm_wr   = wr_en && wr_sel && enabled;

    assign cnt_en = tick && enabled
                 && !(in_wait    && !ctrl_q.wait_run)
                 && !(in_stop    && !ctrl_q.stop_run)
                 && !(dbg_active &&  ctrl_q.debug_halt);

    assign cur_load = rate_load(cur_rate);
    assign load_val = ctrl_wr ? rate_load(wr_data[RATE_W-1:0]) : cur_load;
    assign rst_load = rate_load(ssc_mode ? {RATE_W{1'b1}} : RST_RATE);

    assign fault  = expire || key_bad;
    assign reload = ctrl_wr || key_ok || fault;

    wdog_ctrl_reg #(.RST_RATE(RST_RATE)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ssc_mode (ssc_mode),
        .wr       (ctrl_wr),
        .wdata    (wr_data[CTRL_W-1:0]),
        .ctrl     (ctrl_q)
    );

    wdog_modcnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .rst_load (rst_load),
        .load_val (load_val),
        .quarter  (rate_quarter(cur_rate)),
        .reload   (reload),
        .cnt_en   (cnt_en),
        .cnt      (cnt_val),
        .expire   (expire),
        .early    (early)
    );

    wdog_key_fsm u_key (
        .clk         (clk),
        .rst         (rst),
        .clear       (ctrl_wr || fault),
        .arm_wr      (arm_wr),
        .data        (wr_data),
        .early_block (win_on && early),
        .state       (key_st),
        .key_ok      (key_ok),
        .key_bad     (key_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) wdog_rst_req <= 1'b0;
        else     wdog_rst_req <= fault;
    end

endmodule

// File: rtl/keyseq_wdog_chk.sv
module keyseq_wdog_chk
    import keyseq_wdog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rst_req,
    input logic [RATE_W-1:0] rate,
    input logic              win_en,
    input logic              early,
    input logic              arm_wr,
    input key_state_t        key_st,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cnt_load,
    input logic              cnt_en,
    input logic              reload
);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rate == '0) |=> !rst_req);

    // R6
    req_clears_key_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (key_st == KS_WANT_FIRST));

    // R7
    early_write_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (win_en && early && arm_wr) |=> rst_req);

    // R12
    frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !reload) |=> $stable(cnt));

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= cnt_load);

endmodule

bind keyseq_wdog keyseq_wdog_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rst_req  (wdog_rst_req),
    .rate     (cur_rate),
    .win_en   (win_on),
    .early    (early),
    .arm_wr   (arm_wr),
    .key_st   (key_st),
    .cnt      (cnt_val),
    .cnt_load (cur_load),
    .cnt_en   (cnt_en),
    .reload   (reload)
);

// File: tb/keyseq_wdog_bench.sv
module keyseq_wdog_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ssc_mode = 1'b0;
    logic       in_wait = 1'b0;
    logic       in_stop = 1'b0;
    logic       dbg_active = 1'b0;
    logic       wdog_rst_req;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyseq_wdog u_keyseq_wdog (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .ssc_mode     (ssc_mode),
        .in_wait      (in_wait),
        .in_stop      (in_stop),
        .dbg_active   (dbg_active),
        .wdog_rst_req (wdog_rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts cycles with no request; returns 1 if a request was seen
    task automatic idle_watch(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdog_rst_req) seen = 1;
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic cycles_to_req(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            if (wdog_rst_req) break;
        end
    endtask

    task automatic do_reset(input logic ssc);
        ssc_mode = ssc;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic t_reset_ssc();
        int n;
        do_reset(1'b1);
        check("R9 request low after reset", wdog_rst_req, 0);
        cycles_to_req(70000, n);
        check("R9 ssc default rate 7 period", n, 65536);
        @(negedge clk);
        wr(1'b1, 8'h55);
        check("R9 ssc window off, early 0x55", wdog_rst_req, 0);
        wr(1'b1, 8'hAA);
        check("R9 ssc window off, early 0xAA", wdog_rst_req, 0);
    endtask

    task automatic t_reset_normal();
        int seen;
        do_reset(1'b0);
        idle_watch(300, seen);
        check("R8 rate 0 after reset, no request", seen, 0);
        wr(1'b1, 8'h12);
        check("R8 arm write ignored when off", wdog_rst_req, 0);
    endtask

    task automatic t_timeout(input logic [2:0] rate, input int exp);
        int n;
        wr(1'b0, {5'b0, rate});
        cycles_to_req(70000, n);
        check($sformatf("R2 R3 period for rate %0d", rate), n, exp);
        @(negedge clk);
        check("R3 request lasts one cycle", wdog_rst_req, 0);
    endtask

    task automatic t_service();
        int n;
        wr(1'b0, 8'h01);
        idle(30);
        wr(1'b1, 8'h55);
        check("R4 first key accepted", wdog_rst_req, 0);
        wr(1'b1, 8'hAA);
        check("R4 second key accepted", wdog_rst_req, 0);
        cycles_to_req(1000, n);
        check("R4 service restarts full period", n, 64);
    endtask

    task automatic t_bad_keys();
        int n;
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hAA);
        check("R5 0xAA without 0x55", wdog_rst_req, 1);
        @(negedge clk);
        check("R3 fault request one cycle", wdog_rst_req, 0);
        cycles_to_req(1000, n);
        check("R6 reload after fault request", n, 63);
        wr(1'b1, 8'h55);
        check("R5 0x55 accepted", wdog_rst_req, 0);
        wr(1'b1, 8'h12);
        check("R5 stray byte after 0x55", wdog_rst_req, 1);
        wr(1'b1, 8'h55);
        check("R6 expects 0x55 after request", wdog_rst_req, 0);
        wr(1'b1, 8'hAA);
        check("R6 pair completes after request", wdog_rst_req, 0);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h55);
        check("R5 repeated 0x55", wdog_rst_req, 1);
    endtask

    task automatic t_window();
        int n;
        wr(1'b0, 8'h09);
        wr(1'b1, 8'h55);
        check("R7 write at start of window period", wdog_rst_req, 1);
        wr(1'b0, 8'h09);
        idle(47);
        wr(1'b1, 8'h55);
        check("R7 write one tick before window", wdog_rst_req, 1);
        wr(1'b0, 8'h09);
        idle(48);
        wr(1'b1, 8'h55);
        check("R7 0x55 at window opening", wdog_rst_req, 0);
        wr(1'b1, 8'hAA);
        check("R7 0xAA inside window", wdog_rst_req, 0);
        cycles_to_req(1000, n);
        check("R7 window service restarts period", n, 64);
    endtask

    task automatic t_ctrl_write();
        int n;
        wr(1'b0, 8'h01);
        idle(40);
        wr(1'b0, 8'h01);
        cycles_to_req(1000, n);
        check("R1 control write restarts period", n, 64);
        @(negedge clk);
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hAA);
        check("R1 control write clears key sequence", wdog_rst_req, 1);
    endtask

    task automatic t_freeze(input logic [7:0] ctrl, input int which,
                            input int expect_freeze, input string req);
        int seen;
        int n;
        wr(1'b0, ctrl);
        case (which)
            0: in_wait = 1'b1;
            1: in_stop = 1'b1;
            2: dbg_active = 1'b1;
            default: tick = 1'b0;
        endcase
        if (expect_freeze != 0) begin
            idle_watch(200, seen);
            check({req, " frozen, no request"}, seen, 0);
            in_wait = 1'b0; in_stop = 1'b0; dbg_active = 1'b0; tick = 1'b1;
            cycles_to_req(1000, n);
            check({req, " full period after release"}, n, 64);
        end else begin
            cycles_to_req(1000, n);
            check({req, " keeps counting"}, n, 64);
            in_wait = 1'b0; in_stop = 1'b0; dbg_active = 1'b0; tick = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_ssc();
        t_reset_normal();
        t_timeout(3'd1, 64);
        t_timeout(3'd2, 256);
        t_timeout(3'd3, 1024);
        t_timeout(3'd5, 8192);
        t_service();
        t_bad_keys();
        @(negedge clk);
        t_window();
        @(negedge clk);
        t_ctrl_write();
        @(negedge clk);
        t_freeze(8'h01, 0, 1, "R10 wait, run bit clear");
        t_freeze(8'h11, 0, 0, "R10 wait, run bit set");
        t_freeze(8'h01, 1, 1, "R10 stop, run bit clear");
        t_freeze(8'h21, 1, 0, "R10 stop, run bit set");
        t_freeze(8'h41, 2, 1, "R11 debug, halt bit set");
        t_freeze(8'h01, 2, 0, "R11 debug, halt bit clear");
        t_freeze(8'h01, 3, 1, "R12 tick low");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule